// File: doc/BRIEF.md
# Rotating-Window Register File Controller

This block holds a physical general-register array and presents sixteen logical registers to the pipeline. Which slice is visible depends on a window-base pointer counted in groups of four physical registers. A one-bit-per-group window-start map records which groups begin a live call frame. From that map the controller decides, in one cycle, whether a windowed call, return or frame check needs a spill or a fill, and which size of spill or fill that is.

The pipeline drives one windowed operation per cycle on `op_valid`/`op_code`, together with the status bits it owns: overflow-enable, exception mode and call increment. The controller answers in the same cycle with an exception flag and cause code, a request to enter exception mode, and the computed return PC. The base and start map update on the next clock edge. Two logical read ports and one logical write port give the datapath its normal register access. The spill and fill handlers and the vector dispatch sit outside this block.

Top module: `windowed_regfile`

## Requirements
- R1: Logical register r reads physical register (4*wb + r) mod NPHYS, wrapping past the top of the array. After reset the base is 0, the start map holds only bit 0, and every physical register reads 0.
- R2: A write on the write port takes effect at the next clock edge. A read of the same register in the write cycle returns the old value. With `op_valid` low, `exc_valid` stays low.
- R3: A legal call entry (op 1) needs `op_src` <= 3, `woe`=1 and `excm`=0. With `ci`=`callinc` and `s`=`op_src`, it writes logical register 4*ci+s of the old view with logical s minus 8*`op_data[11:0]`, adds ci to the base, and sets the start bit of the new base.
- R4: An illegal call entry raises cause 7 and leaves the base, the start map and the registers unchanged.
- R5: The window check (op 5) takes a count w=`op_src[1:0]` and finds the smallest n in 1..w whose start bit at base+n is set. If there is no such n, or if `woe`=0 or `excm`=1, nothing happens.
- R6: On a window-check hit, with m = base+n, the base rotates by n and `excm_set` pulses. The cause is 1 if bit m+1 is set, else 2 if bit m+2 is set, else 3. The old base to save is `wb_out` in that cycle.
- R7: For the windowed return (op 2), n is bits 31:30 of logical register 0, and m is the first of 1, 2, 3 for which the start bit at base-m is set (0 if none). The return is illegal, cause 7 with no state change, if n=0, if m is nonzero and differs from n, if `woe`=0, or if `excm`=1.
- R8: A legal return outputs `ret_pc` = {`pc[31:30]`, reg0[29:0]} and subtracts n from the base. If the start bit of the new base is set, the start bit of the old base is cleared.
- R9: If that bit is clear, the return raises underflow cause 3+n (4, 5 or 6), pulses `excm_set` and leaves the start map unchanged, while the base still rotates.
- R10: The stack-move check (op 4) raises cause 8 when none of the start bits at base-1, base-2 and base-3 is set. It never changes the base or the start map.
- R11: Rotate (op 3) adds the signed 4-bit `op_data[3:0]` to the base modulo NPHYS/4. Restore (op 6) loads the base from `owb_in`. Op 7 writes the base from `op_data` modulo NPHYS/4, and op 8 writes the start map from `op_data`.
- R12: When a legal call entry writes a register in the same cycle as the write port, the entry's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data B |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Logical write index |
| wr_data | input | 32 | Write data |
| op_valid | input | 1 | Window operation present this cycle |
| op_code | input | 4 | 0 none, 1 entry, 2 return, 3 rotate, 4 stack-move check, 5 window check, 6 restore, 7 set base, 8 set start map |
| op_data | input | 32 | Immediate or value for the operation |
| op_src | input | 4 | Entry source register, or window-check count in bits 1:0 |
| pc | input | 32 | PC of the operation |
| woe | input | 1 | Window overflow enable |
| excm | input | 1 | Exception mode |
| callinc | input | 2 | Call increment |
| owb_in | input | log2(NPHYS/4) | Saved old base for restore |
| wb_out | output | log2(NPHYS/4) | Current window base |
| ws_out | output | NPHYS/4 | Current window-start map |
| exc_valid | output | 1 | Exception raised this cycle |
| exc_code | output | 4 | Cause: 1-3 overflow 4/8/12, 4-6 underflow 4/8/12, 7 illegal, 8 alloca |
| excm_set | output | 1 | Save old base and enter exception mode |
| ret_pc | output | 32 | Return PC of a legal return, else 0 |

## Verification
The bench uses 32 physical registers, which gives eight groups. For window check, return and stack-move check, it sweeps all 256 start maps against every count or return size. These sweeps separate the smallest-hit search, and the priority among the 4/8/12 variants, from the mistakes of taking the largest hit or testing the wrong neighbour. The return sweep starts from base 1, so the base-minus offsets wrap past zero. Every base is read against tagged physical contents, which separates correct modular mapping from an unwrapped one. Call entry is tried for every increment and source, and again with each illegal condition.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0, OP_ENTRY = 4'd1, OP_RETW = 4'd2, OP_ROTW = 4'd3,
    OP_MOVSP = 4'd4, OP_WCHECK = 4'd5, OP_RESTORE = 4'd6,
    OP_SET_WB = 4'd7, OP_SET_WS = 4'd8
  } wrf_op_e;

  typedef enum logic [3:0] {
    EXC_NONE = 4'd0, EXC_OVF4 = 4'd1, EXC_OVF8 = 4'd2, EXC_OVF12 = 4'd3,
    EXC_UNF4 = 4'd4, EXC_UNF8 = 4'd5, EXC_UNF12 = 4'd6,
    EXC_ILLEGAL = 4'd7, EXC_ALLOCA = 4'd8
  } wrf_exc_e;
endpackage

// File: rtl/wrf_array.sv
module wrf_array #(
  parameter int NPHYS = 64,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(NPHYS)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(NPHYS)-1:0] ra_addr,
  output logic [DW-1:0]            ra_data,
  input  logic [$clog2(NPHYS)-1:0] rb_addr,
  output logic [DW-1:0]            rb_data,
  input  logic [$clog2(NPHYS)-1:0] rc_addr,
  output logic [DW-1:0]            rc_data
);
  logic [DW-1:0] mem [NPHYS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign ra_data = mem[ra_addr];
  assign rb_data = mem[rb_addr];
  assign rc_data = mem[rc_addr];
endmodule

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int NPHYS = 64,
  parameter int DW    = 32
) (
  input  logic [$clog2(NPHYS/4)-1:0] wb,
  input  logic [NPHYS/4-1:0]         ws,
  input  logic                       woe,
  input  logic                       excm,
  input  logic [1:0]                 callinc,
  input  logic                       op_valid,
  input  wrf_op_e                    op,
  input  logic [DW-1:0]              op_data,
  input  logic [3:0]                 op_src,
  input  logic [$clog2(NPHYS/4)-1:0] owb_in,
  input  logic [DW-1:0]              aux_val,
  input  logic [DW-1:0]              pc,
  output logic [$clog2(NPHYS/4)-1:0] wb_nxt,
  output logic [NPHYS/4-1:0]         ws_nxt,
  output logic                       ent_we,
  output logic [$clog2(NPHYS)-1:0]   ent_addr,
  output logic [DW-1:0]              ent_data,
  output logic                       exc_valid,
  output wrf_exc_e                   exc_code,
  output logic                       excm_set,
  output logic [DW-1:0]              ret_pc,
  output logic                       ovf_hit,
  output logic                       unf_hit,
  output logic                       ent_ok,
  output logic                       retw_ok
);
  localparam int NG  = NPHYS / 4;
  localparam int WBW = $clog2(NG);
  localparam int PAW = $clog2(NPHYS);

  // group index moved by a signed distance, modulo NG
  function automatic logic [WBW-1:0] goff(input logic [WBW-1:0] b, input int d);
    logic [WBW-1:0] dd;
    dd = d[WBW-1:0];
    return b + dd;
  endfunction

  function automatic logic [PAW-1:0] phys(input logic [WBW-1:0] b, input logic [3:0] r);
    return {b, 2'b00} + PAW'(r);
  endfunction

  logic     win_ok;
  int       nsel;
  int       msel;
  int       rn;
  logic [WBW-1:0] mgrp;

  assign win_ok = woe && !excm;

  always_comb begin
    wb_nxt    = wb;
    ws_nxt    = ws;
    ent_we    = 1'b0;
    ent_addr  = '0;
    ent_data  = '0;
    exc_valid = 1'b0;
    exc_code  = EXC_NONE;
    excm_set  = 1'b0;
    ret_pc    = '0;
    ovf_hit   = 1'b0;
    unf_hit   = 1'b0;
    ent_ok    = 1'b0;
    retw_ok   = 1'b0;
    nsel      = 0;
    msel      = 0;
    rn        = int'(aux_val[DW-1:DW-2]);
    mgrp      = '0;
    if (op_valid) begin
      case (op)
        OP_ENTRY: begin
          if (op_src > 4'd3 || !win_ok) begin
            exc_valid = 1'b1;
            exc_code  = EXC_ILLEGAL;
          end else begin
            ent_ok   = 1'b1;
            ent_we   = 1'b1;
            ent_addr = phys(wb, {callinc, op_src[1:0]});
            ent_data = aux_val - (DW'(op_data[11:0]) << 3);
            wb_nxt   = goff(wb, int'(callinc));
            ws_nxt   = ws | (NG'(1) << wb_nxt);
          end
        end
        OP_WCHECK: begin
          if (win_ok) begin
            for (int k = 3; k >= 1; k--)
              if (k <= int'(op_src[1:0]) && ws[goff(wb, k)]) nsel = k;
            if (nsel != 0) begin
              ovf_hit   = 1'b1;
              mgrp      = goff(wb, nsel);
              wb_nxt    = mgrp;
              excm_set  = 1'b1;
              exc_valid = 1'b1;
              if (ws[goff(mgrp, 1)])      exc_code = EXC_OVF4;
              else if (ws[goff(mgrp, 2)]) exc_code = EXC_OVF8;
              else                        exc_code = EXC_OVF12;
            end
          end
        end
        OP_RETW: begin
          for (int k = 3; k >= 1; k--)
            if (ws[goff(wb, -k)]) msel = k;
          if (rn == 0 || (msel != 0 && msel != rn) || !win_ok) begin
            exc_valid = 1'b1;
            exc_code  = EXC_ILLEGAL;
          end else begin
            retw_ok = 1'b1;
            ret_pc  = {pc[DW-1:DW-2], aux_val[DW-3:0]};
            wb_nxt  = goff(wb, -rn);
            if (ws[wb_nxt]) begin
              ws_nxt = ws & ~(NG'(1) << wb);
            end else begin
              unf_hit   = 1'b1;
              excm_set  = 1'b1;
              exc_valid = 1'b1;
              exc_code  = wrf_exc_e'(4'(3 + rn));
            end
          end
        end
        OP_MOVSP: begin
          if (!ws[goff(wb, -1)] && !ws[goff(wb, -2)] && !ws[goff(wb, -3)]) begin
            exc_valid = 1'b1;
            exc_code  = EXC_ALLOCA;
          end
        end
        OP_ROTW:    wb_nxt = goff(wb, int'($signed(op_data[3:0])));
        OP_RESTORE: wb_nxt = owb_in;
        OP_SET_WB:  wb_nxt = op_data[WBW-1:0];
        OP_SET_WS:  ws_nxt = op_data[NG-1:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
  import wrf_pkg::*;
#(
  parameter int NPHYS = 64,
  parameter int DW    = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [3:0]                 rd_a_idx,
  output logic [DW-1:0]              rd_a_data,
  input  logic [3:0]                 rd_b_idx,
  output logic [DW-1:0]              rd_b_data,
  input  logic                       wr_en,
  input  logic [3:0]                 wr_idx,
  input  logic [DW-1:0]              wr_data,
  input  logic                       op_valid,
  input  logic [3:0]                 op_code,
  input  logic [DW-1:0]              op_data,
  input  logic [3:0]                 op_src,
  input  logic [DW-1:0]              pc,
  input  logic                       woe,
  input  logic                       excm,
  input  logic [1:0]                 callinc,
  input  logic [$clog2(NPHYS/4)-1:0] owb_in,
  output logic [$clog2(NPHYS/4)-1:0] wb_out,
  output logic [NPHYS/4-1:0]         ws_out,
  output logic                       exc_valid,
  output logic [3:0]                 exc_code,
  output logic                       excm_set,
  output logic [DW-1:0]              ret_pc
);
  localparam int NG  = NPHYS / 4;
  localparam int WBW = $clog2(NG);
  localparam int PAW = $clog2(NPHYS);

  function automatic logic [PAW-1:0] phys(input logic [WBW-1:0] b, input logic [3:0] r);
    return {b, 2'b00} + PAW'(r);
  endfunction

  logic [WBW-1:0] wb_q, wb_nxt;
  logic [NG-1:0]  ws_q, ws_nxt;
  logic           ent_we, ovf_hit, unf_hit, ent_ok, retw_ok;
  logic [PAW-1:0] ent_addr, arr_waddr, aux_addr;
  logic [DW-1:0]  ent_data, arr_wdata, aux_val;
  wrf_op_e        op;
  wrf_exc_e       exc_e;

  assign op        = wrf_op_e'(op_code);
  assign aux_addr  = phys(wb_q, (op == OP_ENTRY) ? op_src : 4'd0);
  assign arr_waddr = ent_we ? ent_addr : phys(wb_q, wr_idx);
  assign arr_wdata = ent_we ? ent_data : wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_q <= '0;
      ws_q <= NG'(1);
    end else begin
      wb_q <= wb_nxt;
      ws_q <= ws_nxt;
    end
  end

  wrf_array #(.NPHYS(NPHYS), .DW(DW)) u_array (
    .clk(clk), .rst_n(rst_n), .we(ent_we | wr_en), .waddr(arr_waddr),
    .wdata(arr_wdata), .ra_addr(phys(wb_q, rd_a_idx)), .ra_data(rd_a_data),
    .rb_addr(phys(wb_q, rd_b_idx)), .rb_data(rd_b_data),
    .rc_addr(aux_addr), .rc_data(aux_val)
  );

  wrf_ctrl #(.NPHYS(NPHYS), .DW(DW)) u_ctrl (
    .wb(wb_q), .ws(ws_q), .woe(woe), .excm(excm), .callinc(callinc),
    .op_valid(op_valid), .op(op), .op_data(op_data), .op_src(op_src),
    .owb_in(owb_in), .aux_val(aux_val), .pc(pc), .wb_nxt(wb_nxt),
    .ws_nxt(ws_nxt), .ent_we(ent_we), .ent_addr(ent_addr), .ent_data(ent_data),
    .exc_valid(exc_valid), .exc_code(exc_e), .excm_set(excm_set),
    .ret_pc(ret_pc), .ovf_hit(ovf_hit), .unf_hit(unf_hit), .ent_ok(ent_ok),
    .retw_ok(retw_ok)
  );

  assign exc_code = exc_e;
  assign wb_out   = wb_q;
  assign ws_out   = ws_q;
endmodule

// File: rtl/wrf_chk.sv
module wrf_chk #(
  parameter int NPHYS = 64
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       op_valid,
  input logic [3:0]                 op_code,
  input logic [$clog2(NPHYS/4)-1:0] wb_out,
  input logic [NPHYS/4-1:0]         ws_out,
  input logic                       exc_valid,
  input logic [3:0]                 exc_code,
  input logic                       excm_set,
  input logic                       ovf_hit,
  input logic                       unf_hit,
  input logic                       ent_ok,
  input logic                       retw_ok
);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !exc_valid);

  assert_entry_marks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd1 && ent_ok) |=> ws_out[wb_out]);

  assert_illegal_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_code == 4'd7) |=> ($stable(wb_out) && $stable(ws_out)));

  assert_overflow_rotates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |=> (wb_out != $past(wb_out)));

  assert_overflow_signals_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_hit |-> (excm_set && exc_valid && exc_code >= 4'd1 && exc_code <= 4'd3));

  assert_return_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retw_ok && !unf_hit) |=> !ws_out[$past(wb_out)]);

  assert_underflow_keeps_map_R9: assert property (@(posedge clk) disable iff (!rst_n)
    unf_hit |=> $stable(ws_out));

  assert_alloca_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && exc_code == 4'd8) |=> ($stable(wb_out) && $stable(ws_out)));
endmodule

bind windowed_regfile wrf_chk #(.NPHYS(NPHYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .wb_out(wb_out), .ws_out(ws_out), .exc_valid(exc_valid), .exc_code(exc_code),
  .excm_set(excm_set), .ovf_hit(ovf_hit), .unf_hit(unf_hit), .ent_ok(ent_ok),
  .retw_ok(retw_ok)
);

// File: tb/sim_windowed_regfile.sv
module sim_windowed_regfile;
  localparam int NP = 32;
  localparam int NG = NP / 4;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0, op_code = 0, op_src = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, op_data = 0, pc = 0, ret_pc;
  logic        wr_en = 0, op_valid = 0, woe = 1, excm = 0;
  logic [1:0]  callinc = 0;
  logic [2:0]  owb_in = 0, wb_out;
  logic [7:0]  ws_out;
  logic        exc_valid, excm_set;
  logic [3:0]  exc_code;

  int n_cmp = 0, n_bad = 0;
  logic        c_valid, c_excm;
  logic [3:0]  c_code;
  logic [31:0] c_ret;

  always #5 clk = ~clk;

  windowed_regfile #(.NPHYS(NP), .DW(32)) u0 (
    .clk(clk), .rst_n(rst_n), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .op_valid(op_valid), .op_code(op_code), .op_data(op_data),
    .op_src(op_src), .pc(pc), .woe(woe), .excm(excm), .callinc(callinc),
    .owb_in(owb_in), .wb_out(wb_out), .ws_out(ws_out), .exc_valid(exc_valid),
    .exc_code(exc_code), .excm_set(excm_set), .ret_pc(ret_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit wbit(input logic [7:0] m, input int idx);
    return m[((idx % NG) + NG) % NG];
  endfunction

  task automatic run_op(input int o, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    op_valid = 1; op_code = 4'(o); op_data = d; op_src = s;
    #2;
    c_valid = exc_valid; c_code = exc_code; c_excm = excm_set; c_ret = ret_pc;
    @(posedge clk); #1;
    op_valid = 0; op_code = 0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_idx = idx; wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic setwin(input int b, input logic [7:0] m);
    run_op(7, 32'(b), 0);
    run_op(8, {24'd0, m}, 0);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    #1;
    check("R1 reset base", 32'(wb_out), 0);
    check("R1 reset map", 32'(ws_out), 32'h1);
    for (int r = 0; r < 16; r++) begin
      rd_a_idx = 4'(r); #1;
      check("R1 reset regs", rd_a_data, 0);
    end
    // R2 idle quiet
    check("R2 idle exc", 32'(exc_valid), 0);

    // R1 mapping: tag every physical register through bases 0 and 4
    setwin(0, 8'h01);
    for (int r = 0; r < 16; r++) wr(4'(r), 32'hA000_0000 + 32'(r));
    setwin(4, 8'h01);
    for (int r = 0; r < 16; r++) wr(4'(r), 32'hA000_0000 + 32'(16 + r));
    for (int b = 0; b < NG; b++) begin
      setwin(b, 8'h01);
      for (int r = 0; r < 16; r++) begin
        rd_a_idx = 4'(r); rd_b_idx = 4'(15 - r); #1;
        check("R1 map A", rd_a_data, 32'hA000_0000 + 32'((4 * b + r) % NP));
        check("R1 map B", rd_b_data, 32'hA000_0000 + 32'((4 * b + 15 - r) % NP));
      end
    end

    // R2 same-cycle read returns old value
    setwin(2, 8'h04);
    @(negedge clk);
    wr_en = 1; wr_idx = 5; wr_data = 32'h5555_1234; rd_a_idx = 5; #2;
    check("R2 old value in write cycle", rd_a_data, 32'hA000_0000 + 32'(13));
    @(posedge clk); #1; wr_en = 0;
    check("R2 new value after edge", rd_a_data, 32'h5555_1234);

    // R3 legal entry, every increment and source
    for (int ci = 0; ci < 4; ci++) begin
      for (int s = 0; s < 4; s++) begin
        setwin(2, 8'h04);
        wr(4'(s), 32'h1000_0000 + 32'(16 * ci + s));
        woe = 1; excm = 0; callinc = 2'(ci);
        run_op(1, 32'(5 + s), 4'(s));
        check("R3 entry no exc", 32'(c_valid), 0);
        check("R3 entry base", 32'(wb_out), 32'((2 + ci) % NG));
        check("R3 entry map", 32'(ws_out), 32'(8'h04 | (8'h01 << ((2 + ci) % NG))));
        rd_a_idx = 4'(s); #1;
        check("R3 entry value", rd_a_data, 32'h1000_0000 + 32'(16 * ci + s) - 32'(8 * (5 + s)));
      end
    end

    // R4 illegal entry
    for (int t = 0; t < 4; t++) begin
      setwin(3, 8'h08);
      woe = (t != 2); excm = (t == 3); callinc = 1;
      run_op(1, 32'd1, (t < 2) ? 4'(4 + t) : 4'd0);
      check("R4 illegal code", {27'd0, c_valid, c_code}, 32'h17);
      check("R4 base kept", 32'(wb_out), 3);
      check("R4 map kept", 32'(ws_out), 32'h08);
    end
    woe = 1; excm = 0;

    // R12 entry beats the write port (logical 4*1+2 = 6)
    setwin(0, 8'h01);
    wr(4'd2, 32'h0000_0800);
    callinc = 1;
    @(negedge clk);
    op_valid = 1; op_code = 1; op_data = 32'd2; op_src = 2;
    wr_en = 1; wr_idx = 6; wr_data = 32'hDEAD_BEEF;
    @(posedge clk); #1;
    op_valid = 0; op_code = 0; wr_en = 0;
    rd_a_idx = 2; #1;
    check("R12 entry value wins", rd_a_data, 32'h0000_0800 - 32'd16);

    // R5/R6 window check over all maps and counts
    for (int m = 0; m < 256; m++) begin
      for (int w = 0; w < 4; w++) begin
        int n, mg, code;
        setwin(5, 8'(m));
        run_op(5, 0, 4'(w));
        n = 0;
        for (int k = w; k >= 1; k--) if (wbit(8'(m), 5 + k)) n = k;
        if (n == 0) begin
          check("R5 no hit", {27'd0, c_valid, c_code}, 0);
          check("R5 base kept", 32'(wb_out), 5);
        end else begin
          mg = 5 + n;
          code = wbit(8'(m), mg + 1) ? 1 : (wbit(8'(m), mg + 2) ? 2 : 3);
          check("R6 overflow code", {26'd0, c_excm, c_valid, c_code}, 32'h30 + 32'(code));
          check("R6 overflow base", 32'(wb_out), 32'(mg % NG));
        end
        check("R5 map kept", 32'(ws_out), 32'(m));
      end
    end
    woe = 0;
    setwin(5, 8'hFF); run_op(5, 0, 4'd3);
    check("R5 disabled by woe", {27'd0, c_valid, c_code}, 0);
    woe = 1; excm = 1;
    setwin(5, 8'hFF); run_op(5, 0, 4'd3);
    check("R5 disabled by excm", {27'd0, c_valid, c_code}, 0);
    excm = 0;

    // R7/R8/R9 windowed return from base 1 (offsets wrap)
    pc = 32'h4123_4567;
    for (int m = 0; m < 256; m++) begin
      for (int n = 0; n < 4; n++) begin
        int ms, nb;
        logic [31:0] r0;
        setwin(1, 8'(m));
        r0 = {2'(n), 30'h0ABC_DEF1};
        wr(4'd0, r0);
        run_op(2, 0, 0);
        ms = 0;
        for (int k = 3; k >= 1; k--) if (wbit(8'(m), 1 - k)) ms = k;
        if (n == 0 || (ms != 0 && ms != n)) begin
          check("R7 illegal return", {27'd0, c_valid, c_code}, 32'h17);
          check("R7 base kept", 32'(wb_out), 1);
          check("R7 map kept", 32'(ws_out), 32'(m));
        end else begin
          nb = (1 - n + NG) % NG;
          check("R8 return pc", c_ret, {2'b01, 30'h0ABC_DEF1});
          check("R8 return base", 32'(wb_out), 32'(nb));
          if (wbit(8'(m), nb)) begin
            check("R8 no exc", {26'd0, c_excm, c_valid, c_code}, 0);
            check("R8 map cleared", 32'(ws_out), 32'(m & ~2));
          end else begin
            check("R9 underflow code", {26'd0, c_excm, c_valid, c_code}, 32'h30 + 32'(3 + n));
            check("R9 map kept", 32'(ws_out), 32'(m));
          end
        end
      end
    end
    woe = 0;
    setwin(1, 8'h01); wr(4'd0, 32'h4000_0000); run_op(2, 0, 0);
    check("R7 return woe off", {27'd0, c_valid, c_code}, 32'h17);
    woe = 1;

    // R10 stack-move check
    for (int m = 0; m < 256; m++) begin
      setwin(0, 8'(m));
      run_op(4, 0, 0);
      check("R10 alloca", {27'd0, c_valid, c_code},
            ((m & 8'hE0) == 0) ? 32'h18 : 32'h0);
      check("R10 base kept", 32'(wb_out), 0);
      check("R10 map kept", 32'(ws_out), 32'(m));
    end

    // R11 rotate, restore, direct writes
    for (int i = 0; i < 16; i++) begin
      setwin(3, 8'h01);
      run_op(3, 32'(i), 0);
      check("R11 rotate", 32'(wb_out), 32'((3 + ((i < 8) ? i : i - 16) + NG) % NG));
    end
    owb_in = 6; run_op(6, 0, 0);
    check("R11 restore", 32'(wb_out), 6);
    run_op(7, 32'd13, 0);
    check("R11 set base modulo", 32'(wb_out), 5);
    run_op(8, 32'h0000_00A5, 0);
    check("R11 set map", 32'(ws_out), 32'hA5);

    summary();
  end
endmodule